// File: doc/BRIEF.md
# Load/Store-Multiple Register Sequencer

This block carries out block-transfer instructions for a 32-bit processor with sixteen general registers. When started, it takes a register mask, a base address, an operation kind (load or store) and a writeback choice. It then moves one register per 32-bit word access over a valid/ready memory port, lowest register index first, at consecutive word addresses. Loads write each returned word into the register file. Stores read each register through a read port and drive it onto the memory write data.

Two writeback flavours exist. A load with writeback leaves the pointer just past the last word, at base plus 4n. A store with writeback pre-decrements, so its words occupy base minus 4n up to base minus 4, and the pointer ends at base minus 4n. A stack form selects the upper eight registers through an 8-bit mask and always uses register 13 as the pointer, with writeback. A load that includes register 15 signals a change of flow and tests register 12 for zero. That test shares the single finishing cycle with the pointer writeback.

A pending interrupt cancels the instruction at once. Register loads already performed stay, but the pointer writeback is dropped, so the instruction can be reissued unchanged.

Top module: `ldstm_seq`

## Requirements
- R1: While reset is held and right after it, busy, done, aborted, mem_valid and rf_we are all low.
- R2: The k-th access (k from 0) targets the k-th set register of the effective mask in ascending index order. Its address is S+4k, where S is the base, or the base minus 4n for a store with writeback.
- R3: On each accepted load access (mem_valid and mem_ready high), rf_we is high in that cycle with rf_waddr equal to that register and rf_wdata equal to mem_rdata. rf_we is high at no other time except R6.
- R4: On a store access, mem_write is 1 and mem_wdata equals the current contents of the register being stored, read through rf_raddr/rf_rdata. On a load access, mem_write is 0.
- R5: With n the number of set bits in the effective mask, busy stays high for 1+n+x+w cycles after start is accepted, and done is high only in the last of them. Here x is 1 when (writeback and n>0) or (load with register 15 in the mask), else 0, and w is the number of stalled cycles.
- R6: When writeback is on and n>0, the done cycle writes the pointer register with base+4n for a load or base-4n for a store.
- R7: A load whose effective mask includes register 15 raises flow_chg in its done cycle. In that cycle, r12_zero is 1 exactly when register 12 holds zero after all of the loads.
- R8: When stack_form=1, mask bit i (i=0..7) selects register 8+i, reg_list[15:8] and ptr_idx are ignored, register 13 is the pointer, and writeback is on.
- R9: An empty effective mask finishes in one busy cycle with done high, no memory access and no register write.
- R10: While mem_valid is high and mem_ready is low, mem_addr, mem_write and the register being transferred hold, and the transfer repeats the next cycle.
- R11: If irq_pend is high during any busy cycle, aborted is high in that cycle, mem_valid, done and rf_we are low, busy drops in the next cycle, and the pointer register keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| is_load | input | 1 | 1 = load from memory, 0 = store to memory |
| wb_en | input | 1 | Pointer writeback (load post-increment, store pre-decrement) |
| stack_form | input | 1 | Stack form: 8-bit mask on R8..R15, pointer R13, writeback forced |
| ptr_idx | input | 4 | Pointer register index for the non-stack forms |
| reg_list | input | 16 | Register mask |
| base_ptr | input | 32 | Current value of the pointer register |
| irq_pend | input | 1 | Interrupt pending; cancels the instruction |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of a completed instruction |
| aborted | output | 1 | Instruction cancelled this cycle |
| flow_chg | output | 1 | Register 15 was loaded (change of flow) |
| r12_zero | output | 1 | Register 12 is zero, valid with flow_chg |

## Verification
Start is sampled on one clock edge, and the first busy cycle (the issue cycle) is the one that follows. Every memory, register-write and completion output is combinational on the state reached at that edge. The bench therefore samples each busy cycle just after the falling edge and counts these cycles from 1. Access number k is expected in the cycle where the k-th handshake completes. Done is expected exactly in cycle 1+n+x+w, where w is the number of stalled cycles the bench itself produced. Aborted is expected in the very cycle the bench raised irq_pend, and busy is expected low one cycle later. The register-file model is updated only from rf_we at rising edges, so the pointer value checked after an abort is the value reached through the ports.

// File: rtl/ldstm_pkg.sv
package ldstm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_XFER  = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/ldstm_pick.sv
module ldstm_pick #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] mask,
  output logic [IW-1:0]   low_idx,
  output logic            any_set,
  output logic [CW-1:0]   set_cnt
);
  always_comb begin
    low_idx = '0;
    any_set = 1'b0;
    set_cnt = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) begin
        low_idx = IW'(i);
        any_set = 1'b1;
      end
    end
    for (int i = 0; i < NREG; i++) begin
      set_cnt = set_cnt + CW'(mask[i]);
    end
  end
endmodule

// File: rtl/ldstm_addr.sv
module ldstm_addr #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [XLEN-1:0] load_val,
  input  logic            step_en,
  output logic [XLEN-1:0] addr
);
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

  logic [XLEN-1:0] addr_d;

  always_comb begin
    addr_d = addr;
    if (load_en) begin
      addr_d = load_val;
    end else if (step_en) begin
      addr_d = addr + WORD_BYTES;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load_en || step_en) begin
      addr <= addr_d;
    end
  end
endmodule

// File: rtl/ldstm_fsm.sv
module ldstm_fsm
  import ldstm_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NREG    = 16,
  parameter int PC_IDX  = 15,
  parameter int TST_IDX = 12,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_load,
  input  logic            wb,
  input  logic [IW-1:0]   ptr_idx,
  input  logic [NREG-1:0] list,
  input  logic [CW-1:0]   cnt,
  input  logic [XLEN-1:0] base,
  input  logic            irq_pend,
  input  logic            mem_ready,
  input  logic [IW-1:0]   cur_idx,
  output logic [NREG-1:0] rem,
  output logic            addr_ld,
  output logic [XLEN-1:0] addr_val,
  output logic            addr_step,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [IW-1:0]   rf_raddr,
  output logic            rf_we,
  output logic [IW-1:0]   rf_waddr,
  output logic            rf_sel_ptr,
  output logic [XLEN-1:0] ptr_new,
  output logic            busy,
  output logic            done,
  output logic            aborted,
  output logic            flow_chg
);
  seq_state_t      state_q, state_d;
  logic [NREG-1:0] rem_d;
  logic            load_q, load_d;
  logic            wb_q, wb_d;
  logic            pc_q, pc_d;
  logic            extra_q, extra_d;
  logic [IW-1:0]   pidx_q, pidx_d;
  logic [XLEN-1:0] ptr_d;
  logic [XLEN-1:0] span;
  logic [NREG-1:0] rem_clr;

  assign span    = XLEN'(cnt) << 2;
  assign rem_clr = rem & (rem - NREG'(1));
  assign busy    = (state_q != ST_IDLE);

  always_comb begin
    state_d    = state_q;
    rem_d      = rem;
    load_d     = load_q;
    wb_d       = wb_q;
    pc_d       = pc_q;
    extra_d    = extra_q;
    pidx_d     = pidx_q;
    ptr_d      = ptr_new;
    addr_ld    = 1'b0;
    addr_val   = base;
    addr_step  = 1'b0;
    mem_valid  = 1'b0;
    mem_write  = 1'b0;
    rf_raddr   = cur_idx;
    rf_we      = 1'b0;
    rf_waddr   = cur_idx;
    rf_sel_ptr = 1'b0;
    done       = 1'b0;
    aborted    = 1'b0;
    flow_chg   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_ISSUE;
          rem_d   = list;
          load_d  = is_load;
          wb_d    = wb && (cnt != '0);
          pc_d    = is_load && list[PC_IDX];
          extra_d = (wb && (cnt != '0)) || (is_load && list[PC_IDX]);
          pidx_d  = ptr_idx;
          ptr_d   = is_load ? (base + span) : (base - span);
          addr_ld = 1'b1;
          addr_val = (!is_load && wb) ? (base - span) : base;
        end
      end
      ST_ISSUE: begin
        if (irq_pend) begin
          aborted = 1'b1;
          state_d = ST_IDLE;
        end else if (rem == '0) begin
          done    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_XFER;
        end
      end
      ST_XFER: begin
        if (irq_pend) begin
          aborted = 1'b1;
          state_d = ST_IDLE;
        end else begin
          mem_valid = 1'b1;
          mem_write = !load_q;
          if (mem_ready) begin
            addr_step = 1'b1;
            rem_d     = rem_clr;
            rf_we     = load_q;
            if (rem_clr == '0) begin
              if (extra_q) begin
                state_d = ST_FIN;
              end else begin
                done    = 1'b1;
                state_d = ST_IDLE;
              end
            end
          end
        end
      end
      ST_FIN: begin
        rf_raddr = IW'(TST_IDX);
        if (irq_pend) begin
          aborted = 1'b1;
          state_d = ST_IDLE;
        end else begin
          done       = 1'b1;
          rf_we      = wb_q;
          rf_waddr   = pidx_q;
          rf_sel_ptr = 1'b1;
          flow_chg   = pc_q;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem     <= '0;
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
      pc_q    <= 1'b0;
      extra_q <= 1'b0;
      pidx_q  <= '0;
      ptr_new <= '0;
    end else begin
      state_q <= state_d;
      rem     <= rem_d;
      load_q  <= load_d;
      wb_q    <= wb_d;
      pc_q    <= pc_d;
      extra_q <= extra_d;
      pidx_q  <= pidx_d;
      ptr_new <= ptr_d;
    end
  end

  // R11
  irq_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && irq_pend) |-> (aborted && !mem_valid && !done && !rf_we));
  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |=> !busy);
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R3
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy);
  // R7
  flow_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flow_chg |-> done);
endmodule

// File: rtl/ldstm_seq.sv
module ldstm_seq #(
  parameter int XLEN     = 32,
  parameter int NREG     = 16,
  parameter int STK_BITS = 8,
  parameter int SP_IDX   = 13,
  parameter int PC_IDX   = 15,
  parameter int TST_IDX  = 12,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_load,
  input  logic            wb_en,
  input  logic            stack_form,
  input  logic [IW-1:0]   ptr_idx,
  input  logic [NREG-1:0] reg_list,
  input  logic [XLEN-1:0] base_ptr,
  input  logic            irq_pend,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ready,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [IW-1:0]   rf_raddr,
  input  logic [XLEN-1:0] rf_rdata,
  output logic            rf_we,
  output logic [IW-1:0]   rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  output logic            busy,
  output logic            done,
  output logic            aborted,
  output logic            flow_chg,
  output logic            r12_zero
);
  logic            rst_meta_n, rst_sn;
  logic [NREG-1:0] eff_list;
  logic [IW-1:0]   eff_ptr;
  logic            eff_wb;
  logic [CW-1:0]   eff_cnt;
  logic [IW-1:0]   unused_idx;
  logic            unused_any;
  logic [NREG-1:0] rem;
  logic [IW-1:0]   cur_idx;
  logic            rem_any;
  logic [CW-1:0]   unused_cnt;
  logic            addr_ld, addr_step, rf_sel_ptr;
  logic [XLEN-1:0] addr_val, ptr_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sn     <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sn     <= rst_meta_n;
    end
  end

  always_comb begin
    if (stack_form) begin
      eff_list = {reg_list[STK_BITS-1:0], {(NREG-STK_BITS){1'b0}}};
      eff_ptr  = IW'(SP_IDX);
      eff_wb   = 1'b1;
    end else begin
      eff_list = reg_list;
      eff_ptr  = ptr_idx;
      eff_wb   = wb_en;
    end
  end

  ldstm_pick #(.NREG(NREG)) i_pick_all (
    .mask(eff_list), .low_idx(unused_idx), .any_set(unused_any), .set_cnt(eff_cnt)
  );

  ldstm_pick #(.NREG(NREG)) i_pick_rem (
    .mask(rem), .low_idx(cur_idx), .any_set(rem_any), .set_cnt(unused_cnt)
  );

  ldstm_addr #(.XLEN(XLEN)) i_addr (
    .clk(clk), .rst_n(rst_sn), .load_en(addr_ld), .load_val(addr_val),
    .step_en(addr_step), .addr(mem_addr)
  );

  ldstm_fsm #(
    .XLEN(XLEN), .NREG(NREG), .PC_IDX(PC_IDX), .TST_IDX(TST_IDX)
  ) i_fsm (
    .clk(clk), .rst_n(rst_sn), .start(start), .is_load(is_load), .wb(eff_wb),
    .ptr_idx(eff_ptr), .list(eff_list), .cnt(eff_cnt), .base(base_ptr),
    .irq_pend(irq_pend), .mem_ready(mem_ready), .cur_idx(cur_idx), .rem(rem),
    .addr_ld(addr_ld), .addr_val(addr_val), .addr_step(addr_step),
    .mem_valid(mem_valid), .mem_write(mem_write), .rf_raddr(rf_raddr),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_sel_ptr(rf_sel_ptr),
    .ptr_new(ptr_new), .busy(busy), .done(done), .aborted(aborted),
    .flow_chg(flow_chg)
  );

  assign mem_wdata = rf_rdata;
  assign rf_wdata  = rf_sel_ptr ? ptr_new : mem_rdata;
  assign r12_zero  = flow_chg && (rf_rdata == '0);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_valid && !mem_ready) |=> ($stable(mem_addr) && $stable(rf_raddr)));
  // R2
  xfer_pending_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_valid |-> rem_any);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !busy |-> (!mem_valid && !rf_we && !done));
endmodule

// File: tb/test_ldstm_seq.sv
module test_ldstm_seq;
  localparam int CLK_T = 10;

  logic        clk, rst_n, start, is_load, wb_en, stack_form, irq_pend;
  logic [3:0]  ptr_idx, rf_raddr, rf_waddr;
  logic [15:0] reg_list;
  logic [31:0] base_ptr, mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic        mem_valid, mem_write, mem_ready, rf_we, busy, done, aborted;
  logic        flow_chg, r12_zero;
  logic [31:0] rf [16];
  logic        pre_en;
  logic [3:0]  pre_idx;
  logic [31:0] pre_val;
  int          vectors = 0;
  int          fails = 0;
  bit          finished = 0;

  ldstm_seq i_ldstm_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .is_load(is_load), .wb_en(wb_en),
    .stack_form(stack_form), .ptr_idx(ptr_idx), .reg_list(reg_list),
    .base_ptr(base_ptr), .irq_pend(irq_pend), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .busy(busy), .done(done), .aborted(aborted), .flow_chg(flow_chg),
    .r12_zero(r12_zero)
  );

  initial clk = 1'b0;
  always #(CLK_T / 2) clk = ~clk;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction

  assign mem_rdata = memf(mem_addr);
  assign rf_rdata  = rf[rf_raddr];

  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    else if (pre_en) rf[pre_idx] <= pre_val;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nth(input logic [15:0] l, input int k);
    int c = 0;
    for (int i = 0; i < 16; i++) begin
      if (l[i]) begin
        if (c == k) return i;
        c++;
      end
    end
    return 0;
  endfunction

  task automatic preset(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    pre_en = 1'b1; pre_idx = idx; pre_val = val;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic run_op(input bit ld, input bit wb, input bit stk,
                        input logic [3:0] pidx, input logic [15:0] lst,
                        input logic [31:0] bs, input int stall, input int ab);
    logic [15:0] el;
    logic [3:0]  ep;
    logic [31:0] snap [16];
    logic [31:0] saddr, nptr, r12e;
    bit ewb, pc, extra, fin, exp_we;
    int n, cyc, k, stalls, lexp;
    el  = stk ? {lst[7:0], 8'h00} : lst;
    ep  = stk ? 4'd13 : pidx;
    ewb = stk | wb;
    n   = $countones(el);
    pc  = ld && el[15];
    extra = (ewb && n > 0) || pc;
    saddr = (!ld && ewb) ? bs - 32'(4 * n) : bs;
    nptr  = ld ? bs + 32'(4 * n) : bs - 32'(4 * n);
    for (int i = 0; i < 16; i++) snap[i] = rf[i];
    if (ld && el[12]) r12e = memf(saddr + 32'(4 * $countones(el[11:0])));
    else r12e = snap[12];
    @(negedge clk);
    start = 1'b1; is_load = ld; wb_en = wb; stack_form = stk; ptr_idx = pidx;
    reg_list = lst; base_ptr = bs;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; k = 0; stalls = 0; fin = 0;
    while (!fin && cyc < 100) begin
      cyc++;
      mem_ready = (stall == 0) || (cyc % 3 != 2);
      irq_pend  = (ab == cyc);
      #1;
      chk(busy, "R5 busy during op", 32'(busy), 1);
      exp_we = (ld && mem_valid && mem_ready) || (done && ewb && n > 0);
      chk(rf_we == exp_we, "R3 R9 rf_we", 32'(rf_we), 32'(exp_we));
      if (mem_valid) begin
        chk(k < n, "R9 access count", k, n);
        chk(mem_addr == saddr + 32'(4 * k), "R2 R10 address", mem_addr, saddr + 32'(4 * k));
        chk(mem_write == !ld, "R4 direction", 32'(mem_write), 32'(!ld));
        if (!mem_ready) stalls++;
        else begin
          if (!ld) chk(mem_wdata == snap[nth(el, k)], "R4 store data", mem_wdata, snap[nth(el, k)]);
          else begin
            chk(rf_waddr == 4'(nth(el, k)), "R3 load index", 32'(rf_waddr), nth(el, k));
            chk(rf_wdata == memf(mem_addr), "R3 load data", rf_wdata, memf(mem_addr));
          end
          k++;
        end
      end
      if (aborted) begin
        chk(cyc == ab, "R11 abort cycle", cyc, ab);
        chk(!mem_valid && !done, "R11 abort quiet", 32'({mem_valid, done}), 0);
        fin = 1;
      end else if (ab == cyc) begin
        chk(0, "R11 aborted missing", 0, 1);
        fin = 1;
      end
      if (done) begin
        lexp = 1 + n + int'(extra) + stalls;
        chk(cyc == lexp, "R5 cycle count", cyc, lexp);
        chk(k == n, "R2 transfer count", k, n);
        chk(flow_chg == pc, "R7 flow_chg", 32'(flow_chg), 32'(pc));
        if (ewb && n > 0) begin
          chk(rf_waddr == ep, "R6 R8 pointer index", 32'(rf_waddr), 32'(ep));
          chk(rf_wdata == nptr, "R6 pointer value", rf_wdata, nptr);
        end
        if (pc) chk(r12_zero == (r12e == 0), "R7 r12_zero", 32'(r12_zero), 32'(r12e == 0));
        fin = 1;
      end
      @(negedge clk);
    end
    irq_pend = 1'b0; mem_ready = 1'b1;
    #1;
    chk(fin, "R5 op completion", 32'(fin), 1);
    chk(!busy, "R5 R11 idle after op", 32'(busy), 0);
    if (ab > 0) chk(rf[ep] == snap[ep], "R11 pointer kept", rf[ep], snap[ep]);
  endtask

  initial begin
    #(CLK_T * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; is_load = 1'b0; wb_en = 1'b0; stack_form = 1'b0;
    ptr_idx = '0; reg_list = '0; base_ptr = '0; irq_pend = 1'b0; mem_ready = 1'b1;
    pre_en = 1'b0; pre_idx = '0; pre_val = '0;
    for (int i = 0; i < 16; i++) rf[i] = 32'h0100_0000 * i + 32'h1234;
    repeat (3) @(negedge clk);
    chk({busy, done, aborted, mem_valid, rf_we} == 5'b0, "R1 reset outputs",
        32'({busy, done, aborted, mem_valid, rf_we}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy, done, aborted, mem_valid, rf_we} == 5'b0, "R1 after reset",
        32'({busy, done, aborted, mem_valid, rf_we}), 0);

    // R2 R3 R4 R5 R6 R7 R10: plain forms, spread of masks, with and without stalls
    for (int k = 0; k < 150; k++) begin
      for (int m = 0; m < 4; m++) begin
        run_op(m[0], m[1], 1'b0, 4'(k % 16), 16'(k * 16'h9E37 ^ (k << 3)),
               32'h2000_0000 + 32'(k * 64), (k % 3 == 0) ? 1 : 0, 0);
      end
    end
    // R8: every stack mask, pops and pushes, upper bits and ptr_idx ignored
    for (int v = 0; v < 256; v++) begin
      run_op(1'b1, 1'b0, 1'b1, 4'(v % 7), {8'(v ^ 8'hC3), 8'(v)},
             32'h3000_0100, (v % 5 == 0) ? 1 : 0, 0);
      run_op(1'b0, 1'b0, 1'b1, 4'(v % 5), {8'(~v), 8'(v)},
             32'h3000_0800, (v % 4 == 1) ? 1 : 0, 0);
    end
    // R9: empty masks in every form
    for (int m = 0; m < 4; m++) run_op(m[0], m[1], 1'b0, 4'd3, 16'h0000, 32'h4000_0000, 0, 0);
    run_op(1'b1, 1'b0, 1'b1, 4'd0, 16'hFF00, 32'h4000_0040, 0, 0);
    run_op(1'b0, 1'b0, 1'b1, 4'd0, 16'hAB00, 32'h4000_0080, 0, 0);
    // R7: register 12 zero and nonzero with PC popped
    preset(4'd12, 32'h0);
    run_op(1'b1, 1'b0, 1'b1, 4'd0, 16'h0080, 32'h5000_0000, 0, 0);
    run_op(1'b1, 1'b1, 1'b0, 4'd2, 16'h8001, 32'h5000_0100, 1, 0);
    preset(4'd12, 32'h0000_0C0C);
    run_op(1'b1, 1'b0, 1'b0, 4'd2, 16'h8002, 32'h5000_0200, 0, 0);
    // R11: abort in every cycle of two sequences, with and without stalls
    for (int a = 1; a <= 7; a++) run_op(1'b1, 1'b1, 1'b0, 4'd3, 16'h90A2, 32'h6000_0000, 0, a);
    for (int a = 1; a <= 6; a++) run_op(1'b0, 1'b1, 1'b0, 4'd2, 16'h00F0, 32'h6000_1000, 0, a);
    for (int a = 1; a <= 8; a++) run_op(1'b0, 1'b0, 1'b1, 4'd0, 16'h001F, 32'h6000_2000, 1, a);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule